// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Controller

This block is the byte-level slave engine for a small two-wire serial memory of 128 or 256 bytes. A separate bus detector feeds it one-cycle pulses for START and STOP, plus strobes marking each rising and each falling edge of the serial clock. The controller shifts in control, address and data bytes. It decides which bytes to acknowledge and keeps one address pointer that reads and writes share. When it is sending, it serialises read data onto the data line.

Received write bytes leave on a one-cycle write port, which carries the address and the data, towards a page buffer that lies outside this block. Read data comes from a synchronous array port with one cycle of latency. While the external self-timed write engine reports busy, the controller acknowledges nothing. A host can therefore poll with a control byte until the write completes. The data output is an active-high pull-down request for an open-drain pad.

Top module: `eeslv_ctrl`

## Requirements
- R1: The control byte is the first byte after START. Its bits 7:4 must equal 1010, bits 3:1 are ignored, and bit 0 selects the direction: 1 reads, 0 writes. On any other code the slave does not acknowledge and ignores all traffic until the next START.
- R2: The slave acknowledges an accepted byte as follows. It asserts `sda_pull` one cycle after the SCL falling strobe that follows the eighth bit. It holds `sda_pull` through the ninth rising strobe, and it releases the line after the falling strobe that follows that ninth rise.
- R3: While `wr_busy` is high at the acknowledge decision, no byte gets an acknowledge, the control byte included. A byte that is refused produces no write, and the slave ignores traffic until the next START.
- R4: In a write, the byte after the control byte is the word address and is loaded into the pointer. Each later byte that is acknowledged is emitted as a one-cycle `wr_valid` pulse carrying the pointer and the byte.
- R5: After each written byte only the low log2(PAGE_BYTES) pointer bits increment, and they wrap within the page. The upper pointer bits do not change.
- R6: A read control byte without a word address (a current-address read) returns the byte at the pointer. After a read the pointer holds the next array address. After a written byte it holds the next address within the same page.
- R7: A random read is made of a write control byte, a word address, a repeated START and a read control byte. It returns data from that address and produces no `wr_valid`.
- R8: In a read, a low on the line during the master's acknowledge slot fetches the next sequential byte. A high there ends the read: `sda_pull` stays low and the slave ignores traffic until START.
- R9: Word address bits at and above log2(MEM_BYTES) are ignored. A sequential read wraps from the last location to 0.
- R10: A START or a STOP discards any partial byte and releases the line. A START then waits for a control byte. A STOP leaves the slave idle until a START.
- R11: After reset `sda_pull`, `wr_valid` and `rd_en` are low and the pointer is 0.
- R12: Read bytes are sent most significant bit first. Each bit is placed after an SCL falling strobe, and `sda_pull` is high for a 0 bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_det | input | 1 | One-cycle START condition pulse |
| stop_det | input | 1 | One-cycle STOP condition pulse |
| scl_rise | input | 1 | Strobe at each SCL rising edge; `sda_in` is sampled here |
| scl_fall | input | 1 | Strobe at each SCL falling edge; the output changes after it |
| sda_in | input | 1 | Resolved data line level |
| wr_busy | input | 1 | Self-timed write in progress |
| sda_pull | output | 1 | Request to pull the data line low |
| wr_valid | output | 1 | Write byte pulse to the page buffer |
| wr_addr | output | ADDR_W | Address of the written byte |
| wr_data | output | 8 | Written byte |
| rd_en | output | 1 | Array read request |
| rd_addr | output | ADDR_W | Array read address |
| rd_data | input | 8 | Array read data, valid one cycle after `rd_en` |

## Verification
`sda_pull` changes one clock after the SCL falling strobe that causes the change. `wr_valid` and `rd_en` appear one clock after the ninth rising strobe. A fetched read byte reaches the serialiser two clocks after `rd_en`, so it is in place well before the next falling strobe. The bench drives every strobe as a single-cycle pulse and leaves three idle cycles on each side of it. It samples the slave's line state just before each rising strobe, which is where a master would sample. Write-port results are checked only after the STOP that follows the byte, when every pulse is certainly complete.

// File: rtl/eeslv_pkg.sv
package eeslv_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CTRL,
    ST_WADDR,
    ST_WDATA,
    ST_RDATA,
    ST_SKIP
  } eeslv_st_t;

  localparam logic [3:0] DEV_CODE = 4'b1010;
  localparam int BYTE_W = 8;
endpackage

// File: rtl/eeslv_rxshift.sv
module eeslv_rxshift #(
  parameter int BITS = 8,
  localparam int CW = $clog2(BITS + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            rise,
  input  logic            din,
  output logic [CW-1:0]   cnt,
  output logic [BITS-1:0] rx
);
  localparam logic [CW-1:0] LAST = CW'(BITS);
  localparam logic [CW-1:0] ONE  = CW'(1);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
      rx  <= '0;
    end else if (rise) begin
      if (cnt == LAST) begin
        cnt <= '0;
      end else begin
        cnt <= cnt + ONE;
        rx  <= {rx[BITS-2:0], din};
      end
    end
  end

  // R10: a condition pulse throws away the partial byte
  assert_clear_count_R10: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));
endmodule

// File: rtl/eeslv_addrptr.sv
module eeslv_addrptr #(
  parameter int ADDR_W = 7,
  parameter int PAGE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              inc_seq,
  input  logic              inc_page,
  output logic [ADDR_W-1:0] ptr,
  output logic [ADDR_W-1:0] ptr_seq_nxt
);
  localparam logic [ADDR_W-1:0] ONE_A = ADDR_W'(1);

  logic [ADDR_W-1:0] page_nxt;

  assign ptr_seq_nxt = ptr + ONE_A;

  generate
    if (PAGE_W < ADDR_W) begin : g_split
      localparam logic [PAGE_W-1:0] ONE_P = PAGE_W'(1);
      assign page_nxt = {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + ONE_P};

      // R5: page increments keep the upper pointer bits
      assert_page_upper_R5: assert property (@(posedge clk) disable iff (rst)
        (inc_page && !load && !inc_seq) |=> $stable(ptr[ADDR_W-1:PAGE_W]));
    end else begin : g_whole
      assign page_nxt = ptr + ONE_A;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)           ptr <= '0;
    else if (load)     ptr <= load_val;
    else if (inc_seq)  ptr <= ptr_seq_nxt;
    else if (inc_page) ptr <= page_nxt;
  end

  // R4: a loaded word address lands in the pointer
  assert_load_ptr_R4: assert property (@(posedge clk) disable iff (rst)
    load |=> (ptr == $past(load_val)));
endmodule

// File: rtl/eeslv_txshift.sv
module eeslv_txshift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  input  logic         shift,
  output logic         msb
);
  logic [W-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst)        sr <= '0;
    else if (load)  sr <= val;
    else if (shift) sr <= {sr[W-2:0], 1'b0};
  end

  assign msb = sr[W-1];
endmodule

// File: rtl/eeslv_ctrl.sv
module eeslv_ctrl
  import eeslv_pkg::*;
#(
  parameter int MEM_BYTES  = 128,
  parameter int PAGE_BYTES = 8,
  parameter int ADDR_W     = $clog2(MEM_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda_in,
  input  logic              wr_busy,
  output logic              sda_pull,
  output logic              wr_valid,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data
);
  localparam int PAGE_W = $clog2(PAGE_BYTES);
  localparam int CW     = $clog2(BYTE_W + 1);
  localparam logic [CW-1:0] LAST = CW'(BYTE_W);

  eeslv_st_t          st;
  logic               ack_q;
  logic               rd_pend;
  logic               clr;
  logic [CW-1:0]      bit_cnt;
  logic [BYTE_W-1:0]  rx;
  logic               last_slot;
  logic               accept;
  logic               give_ack;
  logic               ptr_load, ptr_inc_seq, ptr_inc_page;
  logic [ADDR_W-1:0]  ptr, ptr_seq_nxt;
  logic               tx_shift, tx_msb;
  logic               ack_rise;

  assign clr       = start_det | stop_det;
  assign last_slot = (bit_cnt == LAST);
  assign ack_rise  = scl_rise && last_slot && !clr;

  eeslv_rxshift #(.BITS(BYTE_W)) u_rx (
    .clk (clk), .rst (rst), .clr (clr), .rise (scl_rise), .din (sda_in),
    .cnt (bit_cnt), .rx (rx)
  );

  always_comb begin
    case (st)
      ST_CTRL:           accept = (rx[7:4] == DEV_CODE);
      ST_WADDR, ST_WDATA: accept = 1'b1;
      default:           accept = 1'b0;
    endcase
  end
  assign give_ack = accept && !wr_busy;

  assign ptr_load     = ack_rise && ack_q && (st == ST_WADDR);
  assign ptr_inc_page = ack_rise && ack_q && (st == ST_WDATA);
  assign ptr_inc_seq  = ack_rise && (st == ST_RDATA);

  eeslv_addrptr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ptr (
    .clk (clk), .rst (rst), .load (ptr_load), .load_val (rx[ADDR_W-1:0]),
    .inc_seq (ptr_inc_seq), .inc_page (ptr_inc_page),
    .ptr (ptr), .ptr_seq_nxt (ptr_seq_nxt)
  );

  assign tx_shift = scl_fall && !clr && (st == ST_RDATA) && !last_slot;

  eeslv_txshift #(.W(BYTE_W)) u_tx (
    .clk (clk), .rst (rst), .load (rd_pend), .val (rd_data),
    .shift (tx_shift), .msb (tx_msb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      ack_q    <= 1'b0;
      sda_pull <= 1'b0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      rd_en    <= 1'b0;
      rd_addr  <= '0;
      rd_pend  <= 1'b0;
    end else begin
      wr_valid <= 1'b0;
      rd_en    <= 1'b0;
      rd_pend  <= rd_en;
      if (start_det) begin
        st       <= ST_CTRL;
        ack_q    <= 1'b0;
        sda_pull <= 1'b0;
      end else if (stop_det) begin
        st       <= ST_IDLE;
        ack_q    <= 1'b0;
        sda_pull <= 1'b0;
      end else begin
        if (scl_fall) begin
          if (last_slot) begin
            if (st == ST_RDATA) begin
              sda_pull <= 1'b0;
            end else begin
              sda_pull <= give_ack;
              ack_q    <= give_ack;
            end
          end else if (st == ST_RDATA) begin
            sda_pull <= ~tx_msb;
          end else begin
            sda_pull <= 1'b0;
          end
        end
        if (scl_rise && last_slot) begin
          ack_q <= 1'b0;
          case (st)
            ST_CTRL: begin
              if (!ack_q) begin
                st <= ST_SKIP;
              end else if (rx[0]) begin
                st      <= ST_RDATA;
                rd_en   <= 1'b1;
                rd_addr <= ptr;
              end else begin
                st <= ST_WADDR;
              end
            end
            ST_WADDR: st <= ack_q ? ST_WDATA : ST_SKIP;
            ST_WDATA: begin
              if (ack_q) begin
                wr_valid <= 1'b1;
                wr_addr  <= ptr;
                wr_data  <= rx;
              end else begin
                st <= ST_SKIP;
              end
            end
            ST_RDATA: begin
              if (!sda_in) begin
                rd_en   <= 1'b1;
                rd_addr <= ptr_seq_nxt;
              end else begin
                st <= ST_SKIP;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  // R3: no acknowledge is granted while the write engine is busy
  assert_busy_noack_R3: assert property (@(posedge clk) disable iff (rst)
    (scl_fall && last_slot && wr_busy && (st != ST_RDATA) && !clr) |=> !sda_pull);

  // R1: a foreign device code is never acknowledged
  assert_bad_code_R1: assert property (@(posedge clk) disable iff (rst)
    (scl_fall && last_slot && (st == ST_CTRL) && (rx[7:4] != DEV_CODE) && !clr)
      |=> !sda_pull);

  // R10: STOP releases the line and parks the slave
  assert_stop_idle_R10: assert property (@(posedge clk) disable iff (rst)
    (stop_det && !start_det) |=> (!sda_pull && (st == ST_IDLE)));

  // R8: array fetches only happen inside a read
  assert_fetch_in_read_R8: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> (st == ST_RDATA));

  // R4: write pulses only come out of the data phase of a write
  assert_write_phase_R4: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> (st == ST_WDATA));
endmodule

// File: tb/sim_eeslv_ctrl.sv
module sim_eeslv_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_det = 1'b0, stop_det = 1'b0, scl_rise = 1'b0, scl_fall = 1'b0;
  logic m_sda = 1'b1;
  logic wr_busy = 1'b0;
  logic sda_pull, wr_valid, rd_en;
  logic [AW-1:0] wr_addr, rd_addr;
  logic [7:0] wr_data;
  logic [7:0] rd_data = 8'h00;
  logic sda_bus;

  int total = 0;
  int bad = 0;
  int wr_cnt = 0;
  logic [AW-1:0] last_wa = '0;
  logic [7:0] last_wd = '0;
  logic [7:0] mem [128];
  logic [7:0] exp_mem [128];

  always #(CLK_PERIOD / 2) clk = ~clk;
  assign sda_bus = m_sda & ~sda_pull;

  eeslv_ctrl u0 (
    .clk (clk), .rst (rst), .start_det (start_det), .stop_det (stop_det),
    .scl_rise (scl_rise), .scl_fall (scl_fall), .sda_in (sda_bus),
    .wr_busy (wr_busy), .sda_pull (sda_pull), .wr_valid (wr_valid),
    .wr_addr (wr_addr), .wr_data (wr_data), .rd_en (rd_en),
    .rd_addr (rd_addr), .rd_data (rd_data)
  );

  always @(posedge clk) begin
    if (rd_en) rd_data <= mem[rd_addr];
    if (wr_valid) begin
      mem[wr_addr] <= wr_data;
      wr_cnt  <= wr_cnt + 1;
      last_wa <= wr_addr;
      last_wd <= wr_data;
    end
  end

  // bit16: 1 write / 0 read, [15:8] word address, [7:0] data
  localparam logic [16:0] VEC [8] = '{
    17'h1_10_5A, 17'h1_11_C3, 17'h0_10_00, 17'h0_11_00,
    17'h0_22_00, 17'h1_40_00, 17'h1_7F_FF, 17'h0_7F_00
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_start();
    @(negedge clk) start_det = 1'b1;
    @(negedge clk) start_det = 1'b0;
    tick(3);
  endtask

  task automatic do_stop();
    @(negedge clk) stop_det = 1'b1;
    @(negedge clk) stop_det = 1'b0;
    tick(3);
  endtask

  task automatic clk_bit(input logic mb, output logic slave_low);
    @(negedge clk) m_sda = mb;
    tick(3);
    slave_low = sda_pull;
    scl_rise = 1'b1;
    @(negedge clk) scl_rise = 1'b0;
    tick(3);
    scl_fall = 1'b1;
    @(negedge clk) scl_fall = 1'b0;
    tick(3);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic sl;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], sl);
    clk_bit(1'b1, sl);
    ack = sl;
  endtask

  task automatic recv_byte(input logic m_ack, output logic [7:0] d);
    logic sl;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, sl);
      d[i] = ~sl;
    end
    clk_bit(~m_ack, sl);
  endtask

  task automatic byte_write(input logic [7:0] a, input logic [7:0] d);
    logic k;
    do_start();
    send_byte(8'hA0, k); chk("R2 write control ack", k, 1);
    send_byte(a, k);     chk("R2 word address ack", k, 1);
    send_byte(d, k);     chk("R2 data ack", k, 1);
    do_stop();
    exp_mem[a[AW-1:0]] = d;
  endtask

  task automatic rand_read(input logic [7:0] a, output logic [7:0] d);
    logic k;
    do_start();
    send_byte(8'hA0, k);
    send_byte(a, k);
    do_start();
    send_byte(8'hA1, k); chk("R7 read control ack", k, 1);
    recv_byte(1'b0, d);
    do_stop();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic k, sl;
    logic [7:0] d;
    int w0;
    for (int i = 0; i < 128; i++) begin
      mem[i] = 8'(i * 37 + 5);
      exp_mem[i] = 8'(i * 37 + 5);
    end
    tick(5);
    @(negedge clk) rst = 1'b0;
    tick(2);
    // R11 reset state
    chk("R11 sda_pull after reset", sda_pull, 0);
    chk("R11 wr_valid after reset", wr_valid, 0);
    chk("R11 rd_en after reset", rd_en, 0);
    // R11/R6 pointer starts at 0: current-address read
    do_start();
    send_byte(8'hA1, k); chk("R6 current read ack", k, 1);
    recv_byte(1'b0, d);
    do_stop();
    chk("R11 R6 R12 first current read", d, exp_mem[0]);

    // vector table: byte writes and random reads
    for (int v = 0; v < 8; v++) begin
      if (VEC[v][16]) begin
        w0 = wr_cnt;
        byte_write(VEC[v][15:8], VEC[v][7:0]);
        chk("R4 write count", wr_cnt - w0, 1);
        chk("R4 write address", last_wa, VEC[v][14:8]);
        chk("R4 write data", last_wd, VEC[v][7:0]);
      end else begin
        w0 = wr_cnt;
        rand_read(VEC[v][15:8], d);
        chk("R7 random read data", d, exp_mem[VEC[v][14:8]]);
        chk("R7 no write during read", wr_cnt - w0, 0);
      end
    end

    // R5 page write with rollover, 10 bytes from 0x1E
    w0 = wr_cnt;
    do_start();
    send_byte(8'hA0, k);
    send_byte(8'h1E, k);
    for (int j = 0; j < 10; j++) begin
      send_byte(8'hB0 + 8'(j), k);
      exp_mem[7'h18 | 7'((6 + j) & 7)] = 8'hB0 + 8'(j);
    end
    do_stop();
    chk("R5 page write count", wr_cnt - w0, 10);
    chk("R5 last page address", last_wa, 7'h1F);
    // R6 pointer after write to 0x1F wraps within page to 0x18
    do_start();
    send_byte(8'hA1, k);
    recv_byte(1'b0, d);
    do_stop();
    chk("R6 current read after page write", d, exp_mem[7'h18]);
    chk("R5 rollover overwrote 0x18", d, 8'hB2);
    rand_read(8'h1E, d);
    chk("R5 second pass at 0x1E", d, 8'hB8);

    // R8 R9 sequential read wrap 0x7E,0x7F,0x00,0x01 then nack
    do_start();
    send_byte(8'hA0, k);
    send_byte(8'h7E, k);
    do_start();
    send_byte(8'hA1, k);
    recv_byte(1'b1, d); chk("R8 seq byte 0", d, exp_mem[7'h7E]);
    recv_byte(1'b1, d); chk("R8 seq byte 1", d, exp_mem[7'h7F]);
    recv_byte(1'b1, d); chk("R9 seq wrap to 0", d, exp_mem[7'h00]);
    recv_byte(1'b0, d); chk("R8 seq byte 3", d, exp_mem[7'h01]);
    k = 1'b0;
    for (int i = 0; i < 9; i++) begin
      clk_bit(1'b1, sl);
      k = k | sl;
    end
    chk("R8 line released after master nack", k, 0);
    do_stop();

    // R9 word address MSB ignored
    byte_write(8'h85, 8'h9E);
    chk("R9 msb ignored address", last_wa, 7'h05);
    rand_read(8'h05, d);
    chk("R9 readback", d, 8'h9E);

    // R1 foreign code refused, chip-select bits ignored
    w0 = wr_cnt;
    do_start();
    send_byte(8'hB0, k); chk("R1 foreign code no ack", k, 0);
    send_byte(8'h20, k); chk("R1 ignored until START", k, 0);
    send_byte(8'h11, k);
    do_stop();
    chk("R1 no write after foreign code", wr_cnt - w0, 0);
    do_start();
    send_byte(8'hAE, k); chk("R1 chip-select bits ignored", k, 1);
    send_byte(8'h30, k);
    send_byte(8'h6D, k);
    do_stop();
    chk("R1 write via 0xAE", last_wd, 8'h6D);

    // R3 busy refuses control byte, then mid-transfer
    w0 = wr_cnt;
    wr_busy = 1'b1;
    do_start();
    send_byte(8'hA0, k); chk("R3 no ack while busy", k, 0);
    do_stop();
    wr_busy = 1'b0;
    do_start();
    send_byte(8'hA0, k); chk("R3 ack once idle", k, 1);
    wr_busy = 1'b1;
    send_byte(8'h31, k); chk("R3 address byte refused", k, 0);
    wr_busy = 1'b0;
    send_byte(8'h44, k); chk("R3 skip after refusal", k, 0);
    do_stop();
    chk("R3 no write while busy", wr_cnt - w0, 0);

    // R10 START mid-byte discards partial bits
    do_start();
    clk_bit(1'b1, sl); clk_bit(1'b0, sl); clk_bit(1'b1, sl);
    do_start();
    send_byte(8'hA0, k); chk("R10 control after restart", k, 1);
    send_byte(8'h33, k);
    send_byte(8'h77, k);
    chk("R2 released after ack slot", sda_pull, 0);
    do_stop();
    chk("R10 write after restart", last_wa, 7'h33);
    // R10 STOP mid-byte, then bytes without START are ignored
    do_start();
    clk_bit(1'b1, sl); clk_bit(1'b0, sl);
    do_stop();
    send_byte(8'hA0, k); chk("R10 idle after STOP", k, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule